// File: doc/BRIEF.md
# Burst Column Address Generator

This block keeps the operating mode of a synchronous memory and, from a start column carried by a read or write command, produces the column address of every beat of the burst, one per clock. A mode-set command writes a 12-bit operand that selects burst length, ordering (linear or XOR-interleaved), read latency and whether writes are forced to a single beat. Read and write commands then start a burst. It runs until its last beat, until a stop command, or until a new read or write restarts it at a new column. A full-page burst runs on, wrapping over the whole column space, until it is stopped or replaced.

Commands are decoded from four active-low strobes (select, row, column, write). The block has four states. IDLE waits for a command. BURST emits addresses. HOLD1 and HOLD2 are the two clocks of quiet that follow a mode-set. The transitions are: IDLE to BURST on read or write. BURST to BURST on the next beat or on a restart. BURST to IDLE on the last beat or on stop. IDLE or BURST to HOLD1 on mode-set. HOLD1 to HOLD2, and HOLD2 to IDLE, each unconditionally.

An operand that carries a reserved code is refused as a whole. The previous mode stays in force, and a sticky error flag is raised.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, col_valid and mode_err are 0, the burst length code is 000, ordering is linear, the latency code is 010 and single-write is off.
- R2: A mode-set (cs_n, ras_n, cas_n, we_n all 0) loads operand bits 2:0 as the length code, bit 3 as the ordering (1 = interleaved), bits 6:4 as the latency code and bit 9 as single-write. The values show on the mode outputs after that clock edge.
- R3: Length codes 100, 101 and 110, length code 111 together with interleaved ordering, and latency codes other than 001, 010 and 011 are reserved. Such an operand leaves every mode field unchanged and sets mode_err, which stays 1 until reset.
- R4: A read (strobes 0,1,0,1) or write (0,1,0,0) accepted at an edge drives col_valid high from that edge on, with col_addr equal to the start column (addr bits 7:0). col_write is 1 for a write. One address follows per clock, for 1, 2, 4 or 8 beats (length codes 000, 001, 010, 011), after which col_valid falls.
- R5: In linear ordering, the low bits of the address, as many as log2 of the length, count up from the start value modulo the length. The upper bits stay at their start value.
- R6: In interleaved ordering, the low bits are the start low bits XOR the beat index. The upper bits are held.
- R7: Length code 111 with linear ordering gives a full-page burst. The address steps by one modulo 256 and does not end by itself.
- R8: With single-write set, a write burst has exactly one beat, while a read burst keeps the programmed length.
- R9: A stop command (0,1,1,0) accepted at an edge makes col_valid 0 from that edge on.
- R10: A read or write accepted during a burst restarts it at the new column with the new direction.
- R11: A mode-set ends any burst. Every command sampled on the two edges after a mode-set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Select strobe, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 12 | Mode operand or start column (bits 7:0) |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_write | output | 1 | The current burst is a write |
| mode_bl | output | 3 | Stored burst length code |
| mode_interleave | output | 1 | Stored ordering, 1 = interleaved |
| mode_lat | output | 3 | Stored latency code |
| mode_single_wr | output | 1 | Stored single-write mode |
| mode_err | output | 1 | Sticky reserved-code flag |

## Verification
The bench builds the block with its default parameters: a 12-bit operand and 8-bit columns. With 256 columns, a full-page burst can be driven through its complete wrap from 0xFF to 0x00 and beyond within a few hundred clocks. The same width lets the table place start columns at the top of the space and at block edges, where modulo counting and XOR ordering differ most from a plain increment.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_MODE,
        CMD_READ,
        CMD_WRITE,
        CMD_STOP
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BURST,
        ST_HOLD1,
        ST_HOLD2
    } state_e;

    typedef struct packed {
        logic [2:0] bl;
        logic       interleave;
        logic [2:0] lat;
        logic       single_wr;
    } mode_t;

    localparam logic [2:0] BL_1    = 3'b000;
    localparam logic [2:0] BL_2    = 3'b001;
    localparam logic [2:0] BL_4    = 3'b010;
    localparam logic [2:0] BL_8    = 3'b011;
    localparam logic [2:0] BL_PAGE = 3'b111;

    localparam logic [2:0] LAT_1 = 3'b001;
    localparam logic [2:0] LAT_2 = 3'b010;
    localparam logic [2:0] LAT_3 = 3'b011;

endpackage

// File: rtl/bcg_cmd_decode.sv
module bcg_cmd_decode
    import bcg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        cmd = CMD_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_STOP;
                default: cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
    import bcg_pkg::*;
#(
    parameter int OP_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [OP_W-1:0] op,
    output mode_t           mode,
    output logic            err
);

    mode_t cand;
    logic  bl_ok;
    logic  lat_ok;

    always_comb begin
        cand.bl         = op[2:0];
        cand.interleave = op[3];
        cand.lat        = op[6:4];
        cand.single_wr  = op[9];

        unique case (cand.bl)
            BL_1, BL_2, BL_4, BL_8: bl_ok = 1'b1;
            BL_PAGE:                bl_ok = !cand.interleave;
            default:                bl_ok = 1'b0;
        endcase

        unique case (cand.lat)
            LAT_1, LAT_2, LAT_3: lat_ok = 1'b1;
            default:             lat_ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '{bl: BL_1, interleave: 1'b0, lat: LAT_2, single_wr: 1'b0};
            err  <= 1'b0;
        end else if (load) begin
            if (bl_ok && lat_ok) begin
                mode <= cand;
            end else begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcg_addr_seq.sv
module bcg_addr_seq
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic [COL_W-1:0] start_col,
    input  mode_t            mode,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write,
    output logic             locked
);

    localparam logic [COL_W-1:0] PAGE_MASK = {COL_W{1'b1}};

    state_e           state_q, state_n;
    logic [COL_W-1:0] start_q, start_n;
    logic [COL_W-1:0] cnt_q, cnt_n;
    logic [COL_W-1:0] mask_q, mask_n;
    logic             inter_q, inter_n;
    logic             page_q, page_n;
    logic             wr_q, wr_n;

    logic             is_wr_cmd;
    logic             one_beat;
    logic [COL_W-1:0] new_mask;
    logic             last_beat;
    logic [COL_W-1:0] lin_addr;
    logic [COL_W-1:0] xor_addr;
    logic [COL_W-1:0] low_addr;

    assign is_wr_cmd = (cmd == CMD_WRITE);
    assign one_beat  = is_wr_cmd && mode.single_wr;

    always_comb begin
        new_mask = '0;
        if (!one_beat) begin
            unique case (mode.bl)
                BL_2:    new_mask = COL_W'(1);
                BL_4:    new_mask = COL_W'(3);
                BL_8:    new_mask = COL_W'(7);
                BL_PAGE: new_mask = PAGE_MASK;
                default: new_mask = '0;
            endcase
        end
    end

    assign last_beat = !page_q && (cnt_q == mask_q);

    // next-state process
    always_comb begin
        state_n = state_q;
        start_n = start_q;
        cnt_n   = cnt_q;
        mask_n  = mask_q;
        inter_n = inter_q;
        page_n  = page_q;
        wr_n    = wr_q;
        unique case (state_q)
            ST_IDLE, ST_BURST: begin
                if (cmd == CMD_MODE) begin
                    state_n = ST_HOLD1;
                end else if (cmd == CMD_READ || cmd == CMD_WRITE) begin
                    state_n = ST_BURST;
                    start_n = start_col;
                    cnt_n   = '0;
                    mask_n  = new_mask;
                    inter_n = mode.interleave;
                    page_n  = (mode.bl == BL_PAGE) && !one_beat;
                    wr_n    = is_wr_cmd;
                end else if (state_q == ST_BURST) begin
                    if (cmd == CMD_STOP || last_beat) begin
                        state_n = ST_IDLE;
                    end else begin
                        cnt_n = cnt_q + COL_W'(1);
                    end
                end
            end
            ST_HOLD1: state_n = ST_HOLD2;
            ST_HOLD2: state_n = ST_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            inter_q <= 1'b0;
            page_q  <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_n;
            start_q <= start_n;
            cnt_q   <= cnt_n;
            mask_q  <= mask_n;
            inter_q <= inter_n;
            page_q  <= page_n;
            wr_q    <= wr_n;
        end
    end

    // output process
    always_comb begin
        lin_addr  = start_q + cnt_q;
        xor_addr  = start_q ^ cnt_q;
        low_addr  = inter_q ? xor_addr : lin_addr;
        col_valid = (state_q == ST_BURST);
        col_write = (state_q == ST_BURST) && wr_q;
        locked    = (state_q == ST_HOLD1) || (state_q == ST_HOLD2);
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_addr[b] = mask_q[b] ? low_addr[b] : start_q[b];
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int OP_W  = 12,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic [OP_W-1:0]  addr,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_write,
    output logic [2:0]       mode_bl,
    output logic             mode_interleave,
    output logic [2:0]       mode_lat,
    output logic             mode_single_wr,
    output logic             mode_err
);

    cmd_e  cmd;
    mode_t mode;
    logic  lock_w;
    logic  mode_load;

    bcg_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    assign mode_load = (cmd == CMD_MODE) && !lock_w;

    bcg_mode_reg #(.OP_W(OP_W)) u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode_load),
        .op    (addr),
        .mode  (mode),
        .err   (mode_err)
    );

    bcg_addr_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .start_col (addr[COL_W-1:0]),
        .mode      (mode),
        .col_addr  (col_addr),
        .col_valid (col_valid),
        .col_write (col_write),
        .locked    (lock_w)
    );

    assign mode_bl         = mode.bl;
    assign mode_interleave = mode.interleave;
    assign mode_lat        = mode.lat;
    assign mode_single_wr  = mode.single_wr;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int OP_W  = 12,
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [OP_W-1:0]  addr,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_write,
    input logic [2:0]       mode_bl,
    input logic             mode_interleave,
    input logic [2:0]       mode_lat,
    input logic             mode_single_wr,
    input logic             mode_err,
    input logic             locked
);

    logic c_mode, c_rd, c_wr, c_stop;
    assign c_mode = !cs_n && !ras_n && !cas_n && !we_n;
    assign c_rd   = !cs_n &&  ras_n && !cas_n &&  we_n;
    assign c_wr   = !cs_n &&  ras_n && !cas_n && !we_n;
    assign c_stop = !cs_n &&  ras_n &&  cas_n && !we_n;

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |=> mode_err);

    p_legal_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_bl inside {3'b100, 3'b101, 3'b110}) &&
        !(mode_bl == 3'b111 && mode_interleave) &&
        (mode_lat inside {3'b001, 3'b010, 3'b011}));

    p_mode_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_mode && !locked) |=>
        $stable({mode_bl, mode_interleave, mode_lat, mode_single_wr}));

    p_start_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_rd || c_wr) && !locked) |=>
        (col_valid && col_addr == $past(addr[COL_W-1:0]) && col_write == $past(c_wr)));

    p_single_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && col_write && mode_single_wr && !c_rd && !c_wr) |=> !col_valid);

    p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_stop && !locked) |=> !col_valid);

    p_mode_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mode && !locked) |=> (!col_valid && locked));

    p_lock_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> !col_valid);

endmodule

bind burst_col_gen burst_col_gen_chk #(.OP_W(OP_W), .COL_W(COL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cs_n            (cs_n),
    .ras_n           (ras_n),
    .cas_n           (cas_n),
    .we_n            (we_n),
    .addr            (addr),
    .col_addr        (col_addr),
    .col_valid       (col_valid),
    .col_write       (col_write),
    .mode_bl         (mode_bl),
    .mode_interleave (mode_interleave),
    .mode_lat        (mode_lat),
    .mode_single_wr  (mode_single_wr),
    .mode_err        (mode_err),
    .locked          (lock_w)
);

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;

    localparam logic [3:0] C_MRS  = 4'b0000;
    localparam logic [3:0] C_RD   = 4'b0101;
    localparam logic [3:0] C_WR   = 4'b0100;
    localparam logic [3:0] C_STOP = 4'b0110;
    localparam logic [3:0] C_NOP  = 4'b1111;

    typedef struct packed {
        logic [11:0] op;
        logic [7:0]  start;
        logic        wr;
        logic [7:0]  beats;
        logic [7:0]  a0;
        logic [7:0]  a1;
        logic [7:0]  a2;
        logic [7:0]  a3;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{12'h022, 8'h05, 1'b0, 8'd4, 8'h05, 8'h06, 8'h07, 8'h04},
        '{12'h023, 8'h1E, 1'b0, 8'd8, 8'h1E, 8'h1F, 8'h18, 8'h19},
        '{12'h02B, 8'h1E, 1'b0, 8'd8, 8'h1E, 8'h1F, 8'h1C, 8'h1D},
        '{12'h02A, 8'h41, 1'b1, 8'd4, 8'h41, 8'h40, 8'h43, 8'h42},
        '{12'h021, 8'hFF, 1'b1, 8'd2, 8'hFF, 8'hFE, 8'h00, 8'h00},
        '{12'h020, 8'h33, 1'b0, 8'd1, 8'h33, 8'h00, 8'h00, 8'h00},
        '{12'h222, 8'h06, 1'b1, 8'd1, 8'h06, 8'h00, 8'h00, 8'h00},
        '{12'h222, 8'h06, 1'b0, 8'd4, 8'h06, 8'h07, 8'h04, 8'h05},
        '{12'h032, 8'h9B, 1'b0, 8'd4, 8'h9B, 8'h98, 8'h99, 8'h9A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  col_addr;
    logic        col_valid, col_write;
    logic [2:0]  mode_bl, mode_lat;
    logic        mode_interleave, mode_single_wr, mode_err;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_col_gen uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cs_n            (cs_n),
        .ras_n           (ras_n),
        .cas_n           (cas_n),
        .we_n            (we_n),
        .addr            (addr),
        .col_addr        (col_addr),
        .col_valid       (col_valid),
        .col_write       (col_write),
        .mode_bl         (mode_bl),
        .mode_interleave (mode_interleave),
        .mode_lat        (mode_lat),
        .mode_single_wr  (mode_single_wr),
        .mode_err        (mode_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge; returns at the next falling edge with NOP driven
    task automatic issue(input logic [3:0] c, input logic [11:0] a);
        {cs_n, ras_n, cas_n, we_n} = c;
        addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        addr = '0;
    endtask

    task automatic set_mode(input logic [11:0] op);
        issue(C_MRS, op);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 valid", col_valid, 0);
        chk("R1 err", mode_err, 0);
        chk("R1 bl", mode_bl, 3'b000);
        chk("R1 interleave", mode_interleave, 0);
        chk("R1 lat", mode_lat, 3'b010);
        chk("R1 single", mode_single_wr, 0);
        @(negedge clk);

        // R2 field positions
        set_mode(12'h23A);
        chk("R2 bl", mode_bl, 3'b010);
        chk("R2 interleave", mode_interleave, 1);
        chk("R2 lat", mode_lat, 3'b011);
        chk("R2 single", mode_single_wr, 1);

        // table: R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            int beats;
            set_mode(VECS[v].op);
            issue(VECS[v].wr ? C_WR : C_RD, {4'h0, VECS[v].start});
            beats = 0;
            while (col_valid && beats < 20) begin
                case (beats)
                    0: chk("R4/R5/R6 beat0", col_addr, VECS[v].a0);
                    1: chk("R5/R6 beat1", col_addr, VECS[v].a1);
                    2: chk("R5/R6 beat2", col_addr, VECS[v].a2);
                    3: chk("R5/R6 beat3", col_addr, VECS[v].a3);
                    default: ;
                endcase
                chk("R4 direction", col_write, VECS[v].wr);
                beats++;
                @(negedge clk);
            end
            chk("R4/R8 beat count", beats, VECS[v].beats);
        end

        // R3 reserved codes
        chk("R3 err clear", mode_err, 0);
        set_mode(12'h024);
        chk("R3 err set", mode_err, 1);
        chk("R3 bl kept", mode_bl, 3'b010);
        set_mode(12'h02F);
        chk("R3 page+interleave refused", mode_interleave, 0);
        set_mode(12'h042);
        chk("R3 lat kept", mode_lat, 3'b011);
        set_mode(12'h012);
        chk("R3 lat1 accepted", mode_lat, 3'b001);
        chk("R3 err sticky", mode_err, 1);

        // R7 full page wrap, R9 stop
        begin
            int bad;
            bad = 0;
            set_mode(12'h027);
            issue(C_RD, 12'h0FD);
            for (int i = 0; i < 260; i++) begin
                if (!col_valid || col_addr !== 8'(8'hFD + i)) bad++;
                @(negedge clk);
            end
            chk("R7 full page wrap", bad, 0);
            issue(C_STOP, 12'h000);
            chk("R9 stop ends burst", col_valid, 0);
        end

        // R10 interrupt
        set_mode(12'h023);
        issue(C_RD, 12'h010);
        @(negedge clk);
        chk("R10 pre-interrupt beat1", col_addr, 8'h11);
        issue(C_WR, 12'h050);
        chk("R10 restart addr", col_addr, 8'h50);
        chk("R10 restart direction", col_write, 1);
        @(negedge clk);
        chk("R10 restart next", col_addr, 8'h51);

        // R11 mode-set ends burst, lockout
        issue(C_MRS, 12'h022);
        chk("R11 burst ended", col_valid, 0);
        issue(C_RD, 12'h020);
        chk("R11 read in hold ignored", col_valid, 0);
        issue(C_RD, 12'h020);
        chk("R11 read in hold2 ignored", col_valid, 0);
        issue(C_RD, 12'h020);
        chk("R11 read after hold", col_valid, 1);
        chk("R11 addr after hold", col_addr, 8'h20);
        repeat (4) @(negedge clk);
        chk("R4 burst of 4 done", col_valid, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule